// File: doc/BRIEF.md
# Row-Column 8x8 Tchebichef Transform Sequencer

This block computes the two-dimensional discrete Tchebichef transform of an 8x8 block of signed samples. It splits the work into two one-dimensional passes. The input arrives one row of eight samples per clock. Each row goes through an eight-point transform, and the results fill a row buffer. The buffer is read back one column per clock through a transposition that is wiring only. A second eight-point transform acts on each column and writes its results into a result file. The finished block then leaves one coefficient row per clock, in ascending order of vertical frequency.

The schedule is fixed. There is one clear cycle, then eight fill cycles, one wait cycle, eight column cycles and eight drain cycles. A frame therefore lasts 26 cycles, and the first coefficient row appears 18 clocks after the start edge. Both passes multiply by orthonormal Tchebichef basis values held as signed fractions with 12 fractional bits. Each pass rounds its result to the nearest integer. The intermediate width grows by three bits over the input width, and the output width grows by six bits.

Top module: `tch2d_seq`

## Requirements
- R1: After reset, `busy` and `out_valid` are low. Whenever `out_valid` is low, `out_coef` is all zeros.
- R2: Let `start` be sampled high at clock edge E0 while the block is idle. If rows arrive without gaps, `busy` is high from E0 through E25 and low after E26. The frame is 26 cycles long.
- R3: A `start` pulse sampled while `busy` is high has no effect on the timing or the results of the frame in progress.
- R4: Rows are accepted only during the fill phase, and only on edges where `row_valid` is high. Each such edge takes one row. The rows are taken in order as x = 0..7, where x is the vertical position within the block. A low `row_valid` during fill stalls the schedule by one cycle. Rows offered in any other state, or while idle, are ignored.
- R5: Take X as the input block, indexed X[x][y], with y the sample index within a row. Take B[k][n] as the orthonormal Tchebichef basis, each basis vector signed so that its value at n = 7 is positive. The output Y = B·X·Bᵀ lies within ±3 of the exact value for every coefficient.
- R6: `out_valid` is high for exactly eight consecutive cycles per frame. With no fill stalls, it is high after edges E18 through E25. Beat k carries coefficient row Y[k][·], with Y[k][q] in bits q·OUT_W upward. The beats run in order k = 0..7.
- R7: If every sample of the block has the same value c, then Y[0][0] = 8c within ±3, and every other coefficient is 0 within ±3.
- R8: Full-scale inputs do not overflow. An all -128 block gives Y[0][0] = -1024, and a ±128 checkerboard gives results within tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a frame when sampled high while idle |
| row_valid | input | 1 | Input row strobe |
| row_in | input | 8*IN_W | Eight signed samples; sample y is in bits y·IN_W upward |
| out_valid | output | 1 | Coefficient row valid |
| out_coef | output | 8*OUT_W | Eight signed coefficients; coefficient q is in bits q·OUT_W upward |
| busy | output | 1 | High while a frame is in progress |

## Verification
The bench builds the block with its default parameters. With IN_W = 8, the intermediate is 11 bits and the output is 14 bits. At these widths, the all -128 block and the ±128 checkerboard drive both passes to their largest magnitudes, which exercises the overflow margin of R8. The bench computes the basis in floating point by orthogonalising the monomials, so its reference does not depend on the fixed-point table in the design. Further frames cover a fill stall, junk rows and start pulses offered outside the fill phase, and a long idle stretch with `row_valid` held high.

// File: rtl/tch2d_seq.sv
module tch2d_seq #(
  parameter int IN_W  = 8,
  parameter int MID_W = IN_W + 3,
  parameter int OUT_W = IN_W + 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 row_valid,
  input  logic [8*IN_W-1:0]    row_in,
  output logic                 out_valid,
  output logic [8*OUT_W-1:0]   out_coef,
  output logic                 busy
);
  localparam int FRAC = 12;
  localparam int HALF = 1 << (FRAC - 1);

  typedef enum logic [2:0] {S_IDLE, S_CLEAR, S_FILL, S_GAP, S_COLS, S_DRAIN} state_t;

  state_t   state;
  logic [2:0] cnt;

  logic signed [MID_W-1:0] rbuf [8][8];
  logic signed [OUT_W-1:0] res  [8][8];
  logic signed [MID_W-1:0] t1   [8];
  logic signed [OUT_W-1:0] t2   [8];
  int acc1 [8];
  int acc2 [8];

  // basis value k at position n, Q12; odd k flips sign on the mirrored half
  function automatic int tch(input int k, input int n);
    int m;
    int v;
    m = (n < 4) ? n : 7 - n;
    case (k)
      0: v = 1448;
      1: case (m) 0: v = -2212; 1: v = -1580; 2: v = -948;  default: v = -316;  endcase
      2: case (m) 0: v = 2212;  1: v = 316;   2: v = -948;  default: v = -1580; endcase
      3: case (m) 0: v = -1765; 1: v = 1260;  2: v = 1765;  default: v = 756;   endcase
      4: case (m) 0: v = 1155;  1: v = -2145; 2: v = -495;  default: v = 1485;  endcase
      5: case (m) 0: v = -614;  1: v = 2016;  2: v = -1490; default: v = -1315; endcase
      6: case (m) 0: v = 252;   1: v = -1260; 2: v = 2269;  default: v = -1260; endcase
      default: case (m) 0: v = -70; 1: v = 489; 2: v = -1468; default: v = 2447; endcase
    endcase
    if (n >= 4 && (k % 2) == 1) v = -v;
    return v;
  endfunction

  always_comb begin
    for (int k = 0; k < 8; k++) begin
      acc1[k] = 0;
      acc2[k] = 0;
      for (int n = 0; n < 8; n++) begin
        acc1[k] = acc1[k] + tch(k, n) * int'($signed(row_in[n*IN_W +: IN_W]));
        acc2[k] = acc2[k] + tch(k, n) * int'(rbuf[n][cnt]);
      end
      t1[k] = MID_W'((acc1[k] + HALF) >>> FRAC);
      t2[k] = OUT_W'((acc2[k] + HALF) >>> FRAC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE:  if (start) state <= S_CLEAR;
        S_CLEAR: begin cnt <= '0; state <= S_FILL; end
        S_FILL:  if (row_valid) begin
                   cnt <= cnt + 3'd1;
                   if (cnt == 3'd7) state <= S_GAP;
                 end
        S_GAP:   state <= S_COLS;
        S_COLS:  begin
                   cnt <= cnt + 3'd1;
                   if (cnt == 3'd7) state <= S_DRAIN;
                 end
        default: begin
                   cnt <= cnt + 3'd1;
                   if (cnt == 3'd7) state <= S_IDLE;
                 end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_CLEAR) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) rbuf[i][j] <= '0;
    end else if (state == S_FILL && row_valid) begin
      for (int j = 0; j < 8; j++) rbuf[cnt][j] <= t1[j];
    end
    if (state == S_COLS)
      for (int p = 0; p < 8; p++) res[p][cnt] <= t2[p];
  end

  assign busy      = (state != S_IDLE);
  assign out_valid = (state == S_DRAIN);

  for (genvar q = 0; q < 8; q++) begin : g_out
    assign out_coef[q*OUT_W +: OUT_W] = out_valid ? res[cnt][q] : '0;
  end

  logic [3:0] vrun;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vrun <= '0;
    else        vrun <= out_valid ? vrun + 4'd1 : 4'd0;

  p_run_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> vrun == 4'd8);
  p_first_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> cnt == 3'd0);
  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> state != S_CLEAR);
  p_fill_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && !row_valid) |=> (state == S_FILL && $stable(cnt)));
  p_busy_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid));
endmodule

// File: tb/tch2d_seq_tb_top.sv
module tch2d_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 8;
  localparam int OW = IW + 6;
  localparam real TOL = 3.0;

  logic clk = 0, rst_n = 0, start = 0, row_valid = 0;
  logic [8*IW-1:0] row_in = '0;
  logic out_valid, busy;
  logic [8*OW-1:0] out_coef;

  int n_chk = 0, n_bad = 0;
  int X [8][8];
  real B [8][8];
  real REF [8][8];
  int seed = 12345;

  tch2d_seq #(.IN_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .row_valid(row_valid),
    .row_in(row_in), .out_valid(out_valid), .out_coef(out_coef), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0f expected %0f", req, what, act, exp);
    end
  endtask

  function automatic real el(input int q);
    logic signed [OW-1:0] v;
    v = out_coef[q*OW +: OW];
    return real'(v);
  endfunction

  function automatic int rnd();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return (seed >>> 8) % 256 - 128;
  endfunction

  task automatic build_basis();
    real v [8];
    real d, nrm;
    for (int k = 0; k < 8; k++) begin
      for (int x = 0; x < 8; x++) begin
        v[x] = 1.0;
        for (int e = 0; e < k; e++) v[x] = v[x] * (real'(x) - 3.5);
      end
      for (int j = 0; j < k; j++) begin
        d = 0.0;
        for (int x = 0; x < 8; x++) d = d + v[x] * B[j][x];
        for (int x = 0; x < 8; x++) v[x] = v[x] - d * B[j][x];
      end
      nrm = 0.0;
      for (int x = 0; x < 8; x++) nrm = nrm + v[x] * v[x];
      nrm = $sqrt(nrm);
      if (v[7] < 0.0) nrm = -nrm;
      for (int x = 0; x < 8; x++) B[k][x] = v[x] / nrm;
    end
  endtask

  task automatic compute_ref();
    for (int p = 0; p < 8; p++)
      for (int q = 0; q < 8; q++) begin
        REF[p][q] = 0.0;
        for (int x = 0; x < 8; x++)
          for (int y = 0; y < 8; y++)
            REF[p][q] = REF[p][q] + B[p][x] * real'(X[x][y]) * B[q][y];
      end
  endtask

  task automatic drive_row(input int r);
    for (int y = 0; y < 8; y++) row_in[y*IW +: IW] = IW'(X[r][y]);
  endtask

  task automatic drive_junk();
    for (int y = 0; y < 8; y++) row_in[y*IW +: IW] = IW'(rnd());
  endtask

  task automatic run_frame(input int gap_row, input int gap_len, input bit junk, input string req);
    int ptr, gaps, beat, vfirst, vlast;
    bit ev, eb;
    real a;
    ptr = 0; gaps = gap_len; beat = 0;
    vfirst = 18 + gap_len; vlast = 25 + gap_len;
    compute_ref();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c <= vlast + 2; c++) begin
      ev = (c >= vfirst && c <= vlast);
      eb = (c <= vlast);
      chk(busy == eb, "R2", $sformatf("busy at cycle %0d", c), real'(busy), real'(eb));
      chk(out_valid == ev, "R6", $sformatf("out_valid at cycle %0d", c), real'(out_valid), real'(ev));
      if (ev && out_valid) begin
        for (int q = 0; q < 8; q++) begin
          a = el(q);
          chk((a - REF[beat][q] <= TOL) && (REF[beat][q] - a <= TOL), req,
              $sformatf("Y[%0d][%0d]", beat, q), a, REF[beat][q]);
        end
        beat++;
      end else if (!ev) begin
        chk(out_coef == '0, "R1", $sformatf("out_coef idle at cycle %0d", c), real'(out_coef != '0), 0.0);
      end
      if (c >= 1 && ptr < 8) begin
        if (ptr == gap_row && gaps > 0) begin
          row_valid = 0; drive_junk(); gaps--;
        end else begin
          row_valid = 1; drive_row(ptr); ptr++;
        end
      end else begin
        row_valid = junk;
        drive_junk();
      end
      start = junk && (c == 5 || c == 20);
      @(negedge clk);
    end
    row_valid = 0; start = 0;
  endtask

  task automatic test_reset();
    chk(busy == 0, "R1", "busy after reset", real'(busy), 0.0);
    chk(out_valid == 0, "R1", "out_valid after reset", real'(out_valid), 0.0);
    chk(out_coef == '0, "R1", "out_coef after reset", real'(out_coef != '0), 0.0);
  endtask

  task automatic test_ramp();
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) X[x][y] = x * 13 + y * 7 - 60;
    run_frame(0, 0, 0, "R5");
  endtask

  task automatic test_const();
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) X[x][y] = 37;
    run_frame(0, 0, 0, "R7");
  endtask

  task automatic test_full_scale();
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) X[x][y] = -128;
    run_frame(0, 0, 0, "R8");
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) X[x][y] = ((x + y) % 2 == 1) ? -128 : 127;
    run_frame(0, 0, 0, "R8");
  endtask

  task automatic test_stall();
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) X[x][y] = rnd();
    run_frame(3, 2, 0, "R4");
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) X[x][y] = rnd();
    run_frame(0, 1, 0, "R4");
  endtask

  task automatic test_junk_and_restart();
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) X[x][y] = rnd();
    run_frame(0, 0, 1, "R3");
  endtask

  task automatic test_idle_rows();
    for (int c = 0; c < 30; c++) begin
      row_valid = 1; drive_junk();
      @(negedge clk);
      chk(busy == 0, "R4", "busy with rows but no start", real'(busy), 0.0);
      chk(out_valid == 0, "R4", "out_valid with rows but no start", real'(out_valid), 0.0);
    end
    row_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    build_basis();
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_ramp();
    test_const();
    test_full_scale();
    test_stall();
    test_junk_and_restart();
    test_idle_rows();
    test_ramp();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule